// File: doc/BRIEF.md
# Multiplexed Nine-Digit Seven-Segment Scanner

This block lights a row of nine seven-segment digits through one shared segment bus, enabling only one digit at any moment and stepping through the row in a fixed loop. The row is split into three fixed fields. Five digits show a resistance value, two show a step number and two show a dwell time. Each field arrives as packed BCD nibbles, and the digit that is currently selected is decoded into a segment pattern on the fly.

A single dwell timer decides how long each digit stays selected. With the default count of 30000 cycles and a 6 MHz clock, each digit is held for 5 ms. One pass over all nine digits then takes 45 ms, which is about 22 passes per second, above the 16 per second needed for a steady image. At the start of every digit period, all digit enables are held inactive for a short gap so that the old pattern does not bleed into the next digit. The BCD inputs are plain level signals that are read continuously. There is no handshake, because the display has no notion of a transfer.

Top module: `digit_scan_top`

## Requirements
- R1: While rst_n is low, every bit of dig_en_n is 1 and seg_out is 0. After release, scanning restarts at position 0 with a fresh digit period.
- R2: Positions run 0 to 8 and then wrap to 0. Position p lights dig_en_n[p] (active low). Positions 0 to 4 show res_bcd nibbles 0 to 4 (bits 4p+3..4p, tenths through thousands). Positions 5 and 6 show step_bcd bits 3..0 and 7..4. Positions 7 and 8 show time_bcd bits 3..0 and 7..4.
- R3: Each position lasts exactly DWELL_CYCLES clocks, so one full loop lasts 9*DWELL_CYCLES clocks. The default of 30000 gives 5 ms per digit at 6 MHz.
- R4: During the first BLANK_CYCLES clocks of every position period, all enables are 1 and seg_out is 0. An active enable never moves straight to a different digit.
- R5: Outside the gap, exactly one enable bit is 0.
- R6: seg_out[6:0] maps to segments a..g, active high, at bits 0..6. The codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R7: A nibble above 9 shows a blank digit: seg_out[6:0] = 0.
- R8: seg_out[7] is the decimal point. It is 1 only while position POINT_POS (default 1, the ones digit of the resistance) is lit.
- R9: An input change reaches seg_out in the same cycle while its digit is lit. There is no latching and no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (6 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_bcd | input | 4*RES_DIGITS | Resistance digits, tenths in the low nibble |
| step_bcd | input | 4*STEP_DIGITS | Step number, ones in the low nibble |
| time_bcd | input | 4*TIME_DIGITS | Dwell time, ones in the low nibble |
| seg_out | output | 8 | Shared segment bus, bit 7 is the decimal point |
| dig_en_n | output | RES_DIGITS+STEP_DIGITS+TIME_DIGITS | One-hot active-low digit enables |

## Verification
On every cycle, the assertions check the following:
- at most one enable is active;
- the bus is dark whenever no digit is lit;
- an active enable only ever drops to the idle gap before another digit is lit;
- the internal position advances by exactly one and wraps;
- no digit stays lit longer than its dwell minus the gap;
- nibbles above nine decode to a blank;
- the decimal point appears only at its position.

The exact segment codes, the mapping of each nibble to its position, the full loop length, the reset behaviour and the same-cycle response to input changes are shown only by the bench. The bench sweeps several digit patterns through complete loops in a small configuration and compares every cycle against an arithmetic model.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 8;
  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_DARK = '0;
endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int DWELL_CYCLES = 30000,
  parameter int BLANK_CYCLES = 1,
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             gap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  generate
    if (BLANK_CYCLES == 0) begin : g_nogap
      assign gap = 1'b0;
    end else begin : g_gap
      assign gap = (cnt < CNT_W'(BLANK_CYCLES));
    end
  endgenerate
endmodule

// File: rtl/digit_rotator.sv
module digit_rotator #(
  parameter int NUM_POS = 9,
  localparam int POS_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP = POS_W'(NUM_POS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (advance) begin
      if (pos == TOP) pos <= '0;
      else            pos <= pos + POS_W'(1);
    end
  end
endmodule

// File: rtl/field_select.sv
module field_select
  import scan_pkg::*;
#(
  parameter int NUM_POS = 9,
  localparam int POS_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic [BCD_W*NUM_POS-1:0] digits,
  input  logic [POS_W-1:0]         pos,
  output bcd_t                     nib
);
  bcd_t lane [NUM_POS];

  generate
    for (genvar g = 0; g < NUM_POS; g++) begin : g_lane
      assign lane[g] = digits[g*BCD_W +: BCD_W];
    end
  endgenerate

  always_comb begin
    nib = 4'hF;
    for (int k = 0; k < NUM_POS; k++) begin
      if (pos == POS_W'(k)) nib = lane[k];
    end
  end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import scan_pkg::*;
(
  input  bcd_t       nib,
  output logic [6:0] glyph
);
  always_comb begin
    unique case (nib)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
  end
endmodule

// File: rtl/digit_scan_top.sv
module digit_scan_top
  import scan_pkg::*;
#(
  parameter int DWELL_CYCLES = 30000,
  parameter int BLANK_CYCLES = 1,
  parameter int RES_DIGITS   = 5,
  parameter int STEP_DIGITS  = 2,
  parameter int TIME_DIGITS  = 2,
  parameter int POINT_POS    = 1,
  localparam int NUM_POS = RES_DIGITS + STEP_DIGITS + TIME_DIGITS,
  localparam int POS_W   = (NUM_POS > 1) ? $clog2(NUM_POS) : 1,
  localparam int CNT_W   = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BCD_W*RES_DIGITS-1:0]  res_bcd,
  input  logic [BCD_W*STEP_DIGITS-1:0] step_bcd,
  input  logic [BCD_W*TIME_DIGITS-1:0] time_bcd,
  output logic [SEG_W-1:0]             seg_out,
  output logic [NUM_POS-1:0]           dig_en_n
);
  logic [CNT_W-1:0] dwell_cnt;
  logic             period_end;
  logic             in_gap;
  logic [POS_W-1:0] pos_idx;
  bcd_t             cur_nib;
  logic [6:0]       glyph;
  logic [BCD_W*NUM_POS-1:0] all_digits;

  assign all_digits = {time_bcd, step_bcd, res_bcd};

  dwell_timer #(
    .DWELL_CYCLES(DWELL_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (dwell_cnt),
    .wrap (period_end),
    .gap  (in_gap)
  );

  digit_rotator #(.NUM_POS(NUM_POS)) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(period_end),
    .pos    (pos_idx)
  );

  field_select #(.NUM_POS(NUM_POS)) u_sel (
    .digits(all_digits),
    .pos   (pos_idx),
    .nib   (cur_nib)
  );

  bcd_seg_decoder u_dec (
    .nib  (cur_nib),
    .glyph(glyph)
  );

  generate
    for (genvar g = 0; g < NUM_POS; g++) begin : g_en
      assign dig_en_n[g] = in_gap || (pos_idx != POS_W'(g));
    end
  endgenerate

  always_comb begin
    if (in_gap) seg_out = SEG_DARK;
    else        seg_out = {(pos_idx == POS_W'(POINT_POS)), glyph};
  end
endmodule

// File: rtl/digit_scan_checker.sv
module digit_scan_checker #(
  parameter int DWELL_CYCLES = 30000,
  parameter int BLANK_CYCLES = 1,
  parameter int NUM_POS      = 9,
  parameter int POS_W        = 4,
  parameter int CNT_W        = 15,
  parameter int POINT_POS    = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         seg_out,
  input logic [NUM_POS-1:0] dig_en_n,
  input logic [POS_W-1:0]   pos_idx,
  input logic [CNT_W-1:0]   dwell_cnt,
  input logic [3:0]         cur_nib
);
  logic               idle;
  logic [CNT_W:0]     run_len;
  logic [NUM_POS-1:0] prev_en;

  assign idle = &dig_en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      prev_en <= '1;
    end else begin
      prev_en <= dig_en_n;
      if (idle)                     run_len <= '0;
      else if (dig_en_n == prev_en) run_len <= run_len + (CNT_W+1)'(1);
      else                          run_len <= (CNT_W+1)'(1);
    end
  end

  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dig_en_n));

  assert_dark_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (seg_out == 8'h00));

  assert_gap_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (idle || (dig_en_n == $past(dig_en_n))));

  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_idx) |->
      (pos_idx == (($past(pos_idx) == POS_W'(NUM_POS-1)) ? '0 : $past(pos_idx) + POS_W'(1))));

  assert_dwell_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (CNT_W+1)'(DWELL_CYCLES - BLANK_CYCLES));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dwell_cnt < CNT_W'(DWELL_CYCLES));

  assert_blank_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && (cur_nib > 4'd9)) |-> (seg_out[6:0] == 7'h00));

  assert_point_place_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dig_en_n[POINT_POS] |-> !seg_out[7]);
endmodule

bind digit_scan_top digit_scan_checker #(
  .DWELL_CYCLES(DWELL_CYCLES),
  .BLANK_CYCLES(BLANK_CYCLES),
  .NUM_POS     (NUM_POS),
  .POS_W       (POS_W),
  .CNT_W       (CNT_W),
  .POINT_POS   (POINT_POS)
) i_digit_scan_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .seg_out  (seg_out),
  .dig_en_n (dig_en_n),
  .pos_idx  (pos_idx),
  .dwell_cnt(dwell_cnt),
  .cur_nib  (cur_nib)
);

// File: tb/test_digit_scan_top.sv
module test_digit_scan_top;
  localparam int D  = 6;
  localparam int B  = 2;
  localparam int NP = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] res_bcd = '0;
  logic [7:0]  step_bcd = '0;
  logic [7:0]  time_bcd = '0;
  logic [7:0]  seg_out;
  logic [8:0]  dig_en_n;

  always #10 clk = ~clk;

  digit_scan_top #(.DWELL_CYCLES(D), .BLANK_CYCLES(B)) i_digit_scan_top (
    .clk(clk), .rst_n(rst_n), .res_bcd(res_bcd), .step_bcd(step_bcd),
    .time_bcd(time_bcd), .seg_out(seg_out), .dig_en_n(dig_en_n)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;
  int last_start = -1;

  function automatic logic [6:0] glyph_of(logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [3:0] nib_at(int p);
    if (p < 5)      return res_bcd[4*p +: 4];
    else if (p < 7) return step_bcd[4*(p-5) +: 4];
    else            return time_bcd[4*(p-7) +: 4];
  endfunction

  task automatic expect_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at n=%0d: actual %h expected %h", tag, n, act, exp);
    end
  endtask

  task automatic check_cycle();
    int p = (n / D) % NP;
    int c = n % D;
    logic [8:0] exp_en;
    logic [7:0] exp_seg;
    logic [3:0] v = nib_at(p);
    if (c < B) begin
      exp_en = 9'h1FF;
      exp_seg = 8'h00;
    end else begin
      exp_en = ~(9'b1 << p);
      exp_seg = {(p == 1), glyph_of(v)};
    end
    expect_val((c < B) ? "R4 enables in gap" : "R2 R5 enable position", 32'(dig_en_n), 32'(exp_en));
    expect_val((c < B) ? "R4 dark bus" : ((v > 4'd9) ? "R7 blank code" : "R6 segment code"),
               32'(seg_out[6:0]), 32'(exp_seg[6:0]));
    expect_val("R8 decimal point", 32'(seg_out[7]), 32'(exp_seg[7]));
    if (p == 0 && c == B) begin
      if (last_start >= 0) expect_val("R3 loop length", 32'(n - last_start), 32'(NP * D));
      last_start = n;
    end
  endtask

  task automatic run_cycles(int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      #1;
      check_cycle();
    end
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_val("R1 enables in reset", 32'(dig_en_n), 32'h1FF);
    expect_val("R1 bus in reset", 32'(seg_out), 32'h0);
    rst_n = 1'b1;
    n = 0;
    #1 check_cycle();

    // pattern 1: decimal digits 0..8 across positions
    res_bcd = 20'h43210; step_bcd = 8'h65; time_bcd = 8'h87;
    run_cycles(2 * NP * D);

    // pattern 2: nines and a 1334.5 style resistance
    res_bcd = 20'h13345; step_bcd = 8'h99; time_bcd = 8'h09;
    run_cycles(2 * NP * D);

    // pattern 3: every nibble above nine (R7)
    res_bcd = 20'hABCDE; step_bcd = 8'hFA; time_bcd = 8'hBC;
    run_cycles(NP * D);

    // pattern 4: mixed legal and illegal nibbles
    res_bcd = 20'h9F6A7; step_bcd = 8'h2D; time_bcd = 8'hE3;
    run_cycles(NP * D);

    // R9: change the lit digit mid-period
    while (!(((n / D) % NP) == 0 && (n % D) == B + 1)) run_cycles(1);
    res_bcd[3:0] = 4'd7;
    #1;
    expect_val("R9 live update (digit 7 -> 07h)", 32'(seg_out), 32'h07);
    res_bcd[3:0] = 4'd2;
    #1;
    expect_val("R9 live update", 32'(seg_out), 32'h5B);
    run_cycles(D);

    // R1: reset in the middle of a loop
    run_cycles(3 * D + 3);
    rst_n = 1'b0;
    #1;
    expect_val("R1 enables on mid-run reset", 32'(dig_en_n), 32'h1FF);
    expect_val("R1 bus on mid-run reset", 32'(seg_out), 32'h0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    last_start = -1;
    #1 check_cycle();
    res_bcd = 20'h56789; step_bcd = 8'h10; time_bcd = 8'h42;
    run_cycles(2 * NP * D);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule